// File: doc/BRIEF.md
# Fused Dot-Product Normalize, Round and Sign Stage

This block is the back end of a single-precision unit that forms AB + CD or AB - CD in one fused pass. A wide adder upstream delivers a 73-bit result made of a carry bit and 72 data bits. Alongside it come the effective-operation bit, a leading-zero count from an anticipator, the common exponent of the two products and the sign of the AB product.

The stage first picks one of four conditioning paths for the adder result. The pick depends on the effective operation and the adder carry. The paths are named `PATH_ADD_LOW`, `PATH_ADD_HIGH`, `PATH_SUB_KEEP` and `PATH_SUB_NEG`, and they are chosen by a `unique case`. The block is purely combinational, so these paths are selections made within one evaluation and there are no register states or transitions between them.

The chosen 72-bit field is shifted left by the leading-zero count. The top 27 bits are kept and rounded to a 24-bit significand. The stage then packs the result sign, the adjusted exponent and the 23-bit mantissa into a 32-bit word. Special values, exponent saturation, the anticipator and the adder are outside this stage.

Top module: `fdp_post_norm`

## Requirements
- R1: With `sub_op_i`=0 (add) and adder carry `add_res_i[72]`=0, the field passed to normalization is `add_res_i[71:0]` (path `PATH_ADD_LOW`).
- R2: With `sub_op_i`=0 and `add_res_i[72]`=1, the field is `add_res_i[72:1]` (path `PATH_ADD_HIGH`).
- R3: With `sub_op_i`=1 and `add_res_i[72]`=1, the field is `add_res_i[71:0]` unchanged (path `PATH_SUB_KEEP`).
- R4: With `sub_op_i`=1 and `add_res_i[72]`=0, the field is the two's complement of `add_res_i[71:0]`, modulo 2^72 (path `PATH_SUB_NEG`).
- R5: The field is shifted left by `lead_zeros_i`, and bits [71:45] of the shifted value form the 27-bit normalized value N. Bits N[26:3] form the 24-bit significand.
- R6: One is added to N[26:3] exactly when N[2] AND (N[1] OR N[0]).
- R7: If that increment carries into a 25th bit, rounding overflow is raised and the mantissa is bits [23:1] of the 25-bit sum, which is then zero. Otherwise the mantissa is bits [22:0] of the sum.
- R8: The result exponent is `exp_i` + rounding overflow + (adder carry if `sub_op_i`=0), taken modulo 256 with no saturation.
- R9: The result sign is (carry AND signAB) OR (NOT sub_op AND signAB) OR (sub_op AND NOT carry AND NOT signAB). A value of 1 means negative.
- R10: `result_o` packs sign at bit 31, exponent at bits [30:23] and mantissa at bits [22:0].
- R11: When the conditioned 72-bit field is all zero, `result_o` is 32'h0000_0000, whatever the shift count, exponent or signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| add_res_i | input | 73 | Wide adder result; bit 72 is the carry |
| sub_op_i | input | 1 | Effective operation: 0 add, 1 subtract |
| lead_zeros_i | input | 7 | Left normalization shift count |
| exp_i | input | 8 | Common (larger) exponent of the two products |
| sign_ab_i | input | 1 | Sign of the AB product, 1 negative |
| result_o | output | 32 | Packed single-precision result |

## Verification
Assertions inside the modules hold on every evaluation of the logic. They check the following:
- On the negate path, the conditioned field and the raw bits sum to zero modulo 2^72.
- On the high add path, the field's top bit equals the carry.
- The rounded significand exceeds the truncated one by exactly the round-up decision.
- A rounding overflow always leaves a zero mantissa.
- An add never changes the sign away from signAB.
- The exponent never rises by more than two.
- An all-zero field gives an all-zero word.

Only the bench's sweeps can show three things. The first is that the exact field chosen for each of the four paths reaches the right mantissa bits. The second is the effect of the shift count across its full range. The third is the precise sign table for subtracts.

// File: rtl/fdp_post_norm_pkg.sv
package fdp_post_norm_pkg;

    typedef enum logic [1:0] {
        PATH_ADD_LOW  = 2'b00,
        PATH_ADD_HIGH = 2'b01,
        PATH_SUB_NEG  = 2'b10,
        PATH_SUB_KEEP = 2'b11
    } path_e;

    function automatic path_e pick_path(input logic sub_op, input logic carry);
        return path_e'({sub_op, carry});
    endfunction

endpackage

// File: rtl/fdp_field_select.sv
module fdp_field_select
    import fdp_post_norm_pkg::*;
#(
    parameter int WIDE_W = 72
) (
    input  logic [WIDE_W:0]   raw_i,
    input  logic              sub_op_i,
    output logic [WIDE_W-1:0] field_o,
    output logic              carry_o
);

    path_e path;

    always_comb begin
        path    = pick_path(sub_op_i, raw_i[WIDE_W]);
        carry_o = raw_i[WIDE_W];
        unique case (path)
            PATH_ADD_LOW:  field_o = raw_i[WIDE_W-1:0];
            PATH_ADD_HIGH: field_o = raw_i[WIDE_W:1];
            PATH_SUB_KEEP: field_o = raw_i[WIDE_W-1:0];
            PATH_SUB_NEG:  field_o = ~raw_i[WIDE_W-1:0] + WIDE_W'(1);
        endcase
        if (path == PATH_SUB_NEG) begin
            assert_negate_sum_R4: assert (field_o + raw_i[WIDE_W-1:0] == '0)
                else $error("negated field does not cancel raw bits");
        end
        if (path == PATH_ADD_HIGH) begin
            assert_high_top_R2: assert (field_o[WIDE_W-1] == carry_o)
                else $error("high add path lost the carry bit");
        end
    end

endmodule

// File: rtl/fdp_normalize.sv
module fdp_normalize #(
    parameter int WIDE_W = 72,
    parameter int NORM_W = 27,
    parameter int LZ_W   = 7
) (
    input  logic [WIDE_W-1:0] field_i,
    input  logic [LZ_W-1:0]   shamt_i,
    output logic [NORM_W-1:0] norm_o
);

    localparam int DROP_W = WIDE_W - NORM_W;

    logic [WIDE_W-1:0] shifted;

    always_comb begin
        shifted = field_i << shamt_i;
        norm_o  = NORM_W'(shifted >> DROP_W);
    end

endmodule

// File: rtl/fdp_round.sv
module fdp_round #(
    parameter int NORM_W = 27,
    parameter int MANT_W = 23
) (
    input  logic [NORM_W-1:0] norm_i,
    output logic [MANT_W-1:0] mant_o,
    output logic              ovf_o
);

    localparam int SIG_W = MANT_W + 1;

    logic             rnd_bit, grd_bit, stk_bit, bump;
    logic [SIG_W-1:0] upper;
    logic [SIG_W:0]   summed;

    always_comb begin
        rnd_bit = norm_i[2];
        grd_bit = norm_i[1];
        stk_bit = norm_i[0];
        upper   = norm_i[NORM_W-1:3];
        bump    = rnd_bit & (grd_bit | stk_bit);
        summed  = {1'b0, upper} + {{SIG_W{1'b0}}, bump};
        ovf_o   = summed[SIG_W];
        if (ovf_o) mant_o = summed[SIG_W-1:1];
        else       mant_o = summed[MANT_W-1:0];

        assert_round_step_R6: assert (summed - {1'b0, upper} == {{SIG_W{1'b0}}, bump})
            else $error("rounded significand differs from truncated by more than the bump");
        if (ovf_o) begin
            assert_wrap_zero_R7: assert (mant_o == '0)
                else $error("rounding overflow left a nonzero mantissa");
        end
    end

endmodule

// File: rtl/fdp_post_norm.sv
module fdp_post_norm
    import fdp_post_norm_pkg::*;
#(
    parameter int WIDE_W = 72,
    parameter int MANT_W = 23,
    parameter int EXP_W  = 8,
    parameter int LZ_W   = $clog2(WIDE_W)
) (
    input  logic [WIDE_W:0]          add_res_i,
    input  logic                     sub_op_i,
    input  logic [LZ_W-1:0]          lead_zeros_i,
    input  logic [EXP_W-1:0]         exp_i,
    input  logic                     sign_ab_i,
    output logic [MANT_W+EXP_W:0]    result_o
);

    localparam int NORM_W = MANT_W + 4;
    localparam int WORD_W = MANT_W + EXP_W + 1;

    logic [WIDE_W-1:0] field;
    logic              carry;
    logic [NORM_W-1:0] norm;
    logic [MANT_W-1:0] mant;
    logic              ovf;
    logic              sign_w;
    logic [EXP_W-1:0]  exp_w;
    logic [EXP_W-1:0]  exp_rise;

    fdp_field_select #(.WIDE_W(WIDE_W)) u_sel (
        .raw_i    (add_res_i),
        .sub_op_i (sub_op_i),
        .field_o  (field),
        .carry_o  (carry)
    );

    fdp_normalize #(.WIDE_W(WIDE_W), .NORM_W(NORM_W), .LZ_W(LZ_W)) u_norm (
        .field_i (field),
        .shamt_i (lead_zeros_i),
        .norm_o  (norm)
    );

    fdp_round #(.NORM_W(NORM_W), .MANT_W(MANT_W)) u_rnd (
        .norm_i (norm),
        .mant_o (mant),
        .ovf_o  (ovf)
    );

    always_comb begin
        sign_w = (carry & sign_ab_i) | (~sub_op_i & sign_ab_i)
               | (sub_op_i & ~carry & ~sign_ab_i);
        exp_w  = exp_i + {{(EXP_W-1){1'b0}}, ovf}
               + {{(EXP_W-1){1'b0}}, (~sub_op_i & carry)};
        if (field == '0) result_o = '0;
        else             result_o = {sign_w, exp_w, mant};

        exp_rise = exp_w - exp_i;
        if (!sub_op_i) begin
            assert_add_sign_R9: assert (sign_w == sign_ab_i)
                else $error("effective add changed the product sign");
        end
        assert_exp_rise_R8: assert (exp_rise <= EXP_W'(2))
            else $error("exponent rose by more than two");
        if (field == '0) begin
            assert_zero_word_R11: assert (result_o == WORD_W'(0))
                else $error("zero field gave a nonzero word");
        end
    end

endmodule

// File: tb/sim_fdp_post_norm.sv
module sim_fdp_post_norm;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [72:0] add_res;
    logic        sub_op;
    logic [6:0]  lz;
    logic [7:0]  exp_in;
    logic        sab;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdp_post_norm u0 (
        .add_res_i    (add_res),
        .sub_op_i     (sub_op),
        .lead_zeros_i (lz),
        .exp_i        (exp_in),
        .sign_ab_i    (sab),
        .result_o     (result)
    );

    function automatic logic [71:0] cond_field(logic [72:0] s, logic op);
        case ({op, s[72]})
            2'b00:   return s[71:0];
            2'b01:   return s[72:1];
            2'b11:   return s[71:0];
            default: return 72'd0 - s[71:0];
        endcase
    endfunction

    function automatic logic [31:0] ref_out(logic [72:0] s, logic op, logic [6:0] sh,
                                            logic [7:0] e, logic sa);
        logic [71:0] f, shf;
        logic [26:0] n;
        logic [24:0] r;
        logic        up, ov, sg;
        logic [22:0] m;
        logic [7:0]  ex;
        f = cond_field(s, op);
        if (f == 0) return 32'h0;
        shf = f << sh;
        n   = shf[71:45];
        up  = n[2] & (n[1] | n[0]);
        r   = {1'b0, n[26:3]} + {24'd0, up};
        ov  = r[24];
        m   = ov ? r[23:1] : r[22:0];
        ex  = e + {7'd0, ov} + {7'd0, (~op & s[72])};
        sg  = (s[72] & sa) | (~op & sa) | (op & ~s[72] & ~sa);
        return {sg, ex, m};
    endfunction

    function automatic logic [6:0] count_lz(logic [71:0] f);
        for (int i = 71; i >= 0; i--) if (f[i]) return 7'(71 - i);
        return 7'd0;
    endfunction

    task automatic apply(logic [72:0] s, logic op, logic [6:0] sh, logic [7:0] e, logic sa);
        @(posedge clk);
        add_res = s; sub_op = op; lz = sh; exp_in = e; sab = sa;
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr_a, lfsr_b;
        logic [72:0] s;
        logic [71:0] f;
        logic        op;
        logic [31:0] e;
        add_res = '0; sub_op = 0; lz = 0; exp_in = 0; sab = 0;
        @(negedge clk);
        check("R11 reset-state zero", result, 32'h0);

        // R1: add, carry 0, field = low bits; bit71 only -> mant 0, exp unchanged
        apply({1'b0, 72'h80_0000_0000_0000_0000}, 0, 0, 8'h7F, 0);
        check("R1 add low path", result, 32'h3F800000);
        // R2 and R10: add, carry 1, field = bits 72..1 -> exp +1, packed word
        apply({1'b1, 72'h0}, 0, 0, 8'h80, 0);
        check("R2 add high path", result, 32'h40800000);
        check("R10 packing sign/exp/mant", result, {1'b0, 8'h81, 23'h0});
        // R3: sub, carry 1, unchanged; sign from signAB
        apply({1'b1, 72'h80_0000_0000_0000_0000}, 1, 0, 8'h10, 1);
        check("R3 sub keep path", result, 32'h88000000);
        // R4 and R7: sub, carry 0, raw 1 -> field all ones -> round overflow
        apply({1'b0, 72'h1}, 1, 0, 8'h7F, 0);
        check("R4 sub negate path", result, 32'hC0000000);
        check("R7 overflow mantissa zero exp+1", result, 32'hC0000000);
        // R5: bits 60,59 with shift 11
        apply({1'b0, 72'h0} | (73'd3 << 59), 0, 7'd11, 8'h7F, 0);
        check("R5 shift and extract", result, 32'h3FC00000);
        // R6: round, guard set -> bump
        apply({1'b0, 72'h0} | (73'd1 << 71) | (73'd3 << 46), 0, 0, 8'h7F, 0);
        check("R6 round up", result, 32'h3F800001);
        apply({1'b0, 72'h0} | (73'd1 << 71) | (73'd1 << 47), 0, 0, 8'h7F, 0);
        check("R6 round bit alone no bump", result, 32'h3F800000);
        apply({1'b0, 72'h0} | (73'd1 << 71) | (73'd3 << 45), 0, 0, 8'h7F, 0);
        check("R6 guard and sticky without round", result, 32'h3F800000);
        // R8: exponent wrap with carry and overflow
        apply({1'b1, 72'hFF_FFFF_FF00_0000_0000}, 0, 0, 8'hFE, 1);
        check("R8 exponent wraps mod 256", result, ref_out({1'b1, 72'hFF_FFFF_FF00_0000_0000}, 0, 0, 8'hFE, 1));
        // R11: zero field with various inputs
        apply(73'h0, 0, 7'd5, 8'h44, 1);
        check("R11 zero field add", result, 32'h0);
        apply({1'b1, 72'h0}, 1, 7'd0, 8'h90, 1);
        check("R11 zero field sub", result, 32'h0);

        // R9: sign table across all op/carry/signAB
        for (int k = 0; k < 8; k++) begin
            s = {k[1], 72'h40_0000_0000_0000_0000};
            apply(s, k[0], count_lz(cond_field(s, k[0])), 8'h60, k[2]);
            check("R9 sign table", {31'd0, result[31]}, {31'd0, ref_out(s, k[0], count_lz(cond_field(s, k[0])), 8'h60, k[2])[31]});
        end

        // sweep: every shift count on every path
        for (int p = 0; p < 4; p++) begin
            for (int sh = 0; sh < 72; sh++) begin
                op = p[1];
                if (p == 2) s = {1'b0, 72'd0 - ((72'd1 << (71 - sh)) | 72'h5)};
                else if (p == 1) s = {1'b1, ((72'd1 << (71 - sh)) | 72'h7) << 1} ;
                else s = {p[0], (72'd1 << (71 - sh)) | 72'h6};
                f = cond_field(s, op);
                apply(s, op, count_lz(f), 8'(sh + 20), sh[0]);
                case (p)
                    0: check("R1 sweep", result, ref_out(s, op, count_lz(f), 8'(sh + 20), sh[0]));
                    1: check("R2 sweep", result, ref_out(s, op, count_lz(f), 8'(sh + 20), sh[0]));
                    2: check("R4 sweep", result, ref_out(s, op, count_lz(f), 8'(sh + 20), sh[0]));
                    default: check("R3 sweep", result, ref_out(s, op, count_lz(f), 8'(sh + 20), sh[0]));
                endcase
            end
        end

        // pseudo-random sweep
        lfsr_a = 64'h1234_5678_9ABC_DEF1;
        lfsr_b = 64'h0F1E_2D3C_4B5A_6978;
        for (int n = 0; n < 3000; n++) begin
            lfsr_a = {lfsr_a[62:0], lfsr_a[63] ^ lfsr_a[62] ^ lfsr_a[60] ^ lfsr_a[59]};
            lfsr_b = {lfsr_b[62:0], lfsr_b[63] ^ lfsr_b[62] ^ lfsr_b[60] ^ lfsr_b[59]};
            s  = {lfsr_a[9:0], lfsr_b[62:0]} >> lfsr_a[20:15];
            s[72] = lfsr_a[30];
            op = lfsr_a[31];
            e  = {24'd0, lfsr_b[40:33]};
            f  = cond_field(s, op);
            apply(s, op, count_lz(f), e[7:0], lfsr_a[50]);
            check("R5 random normalize/round", result, ref_out(s, op, count_lz(f), e[7:0], lfsr_a[50]));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule